// File: doc/BRIEF.md
# Fetch PC Redirect Arbiter

This block is the next-PC controller at the front of a pipeline in which two later stages may steer fetch: the decode stage, which checks direction guesses, and the execute stage, which resolves every control instruction. It holds the fetch PC and two epoch bits. One bit is the fetch stage's view of the execute epoch, the other its view of the decode epoch. Each cycle it picks one of four actions: take an execute redirect, apply a decode redirect, discard a stale decode redirect, or fetch sequentially using the guess from a next-address predictor.

Each execute result is accepted in the cycle it shows up and is passed on at once as a training strobe for the next-address predictor, whether or not it mispredicted. A mispredicting execute result always wins. A decode redirect is applied only when the execute epoch it carries matches the fetch copy, so that redirects from instructions already overtaken by an execute redirect are discarded. Each fetched tag carries the PC, the predicted PC and both epoch bits, so the later stages can spot wrong-path work.

Top module: `fetch_redirect_arbiter`

## Requirements
- R1: An execute message is accepted (`exe_ready` high) in the same cycle that `exe_valid` is high. In that same cycle `train_valid` is high and `train_pc`, `train_target`, `train_taken` and `train_mispred` equal the message fields. When no message is present, `train_valid` is low.
- R2: An execute message with `exe_mispred` set loads `exe_target` into the PC on the next clock edge and inverts the execute-epoch bit carried in later tags.
- R3: In a cycle with a mispredicting execute message, no tag is emitted (`tag_valid` low) and a pending decode message is not accepted (`dec_ready` low). That decode message stays pending for a later cycle.
- R4: A decode message whose `dec_eep` equals the current execute-epoch bit, arriving with no mispredicting execute message, is accepted. It loads `dec_target` into the PC and inverts the decode-epoch bit. No tag is emitted in that cycle.
- R5: A decode message whose `dec_eep` differs from the current execute-epoch bit is still accepted, but the PC and both epoch bits keep their values. No tag is emitted in that cycle.
- R6: With no mispredicting execute message and no decode message, `tag_valid` is high. The tag carries PC, `pred_next_pc` (the predictor's answer for `pred_query_pc`, which equals the PC), and both epoch bits. When `tag_ready` is high, the PC becomes the predicted PC on the next edge.
- R7: While a tag is offered and `tag_ready` is low, the PC and the tag contents hold.
- R8: After reset, the PC equals `RESET_PC` and both epoch bits are 0.
- R9: An execute message without a mispredict does not block decode handling: a pending decode message is processed in the same cycle as the training strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exe_valid | input | 1 | Execute resolution message present |
| exe_pc | input | ADDR_W | PC of the resolved control instruction |
| exe_target | input | ADDR_W | Resolved next PC |
| exe_taken | input | 1 | Branch was taken |
| exe_mispred | input | 1 | Fetch guess was wrong |
| exe_ready | output | 1 | Execute message consumed this cycle |
| dec_valid | input | 1 | Decode redirect message present |
| dec_target | input | ADDR_W | Decode's corrected next PC |
| dec_eep | input | 1 | Execute epoch the decode message was made under |
| dec_ready | output | 1 | Decode message consumed this cycle |
| pred_query_pc | output | ADDR_W | PC presented to the next-address predictor |
| pred_next_pc | input | ADDR_W | Predictor's guess for pred_query_pc |
| train_valid | output | 1 | Predictor training strobe |
| train_pc | output | ADDR_W | Training: instruction PC |
| train_target | output | ADDR_W | Training: resolved next PC |
| train_taken | output | 1 | Training: taken flag |
| train_mispred | output | 1 | Training: mispredict flag |
| tag_valid | output | 1 | Fetched-instruction tag offered |
| tag_ready | input | 1 | Downstream accepts the tag |
| tag_pc | output | ADDR_W | Tag: fetch PC |
| tag_ppc | output | ADDR_W | Tag: predicted next PC |
| tag_eep | output | 1 | Tag: execute-epoch bit |
| tag_dep | output | 1 | Tag: decode-epoch bit |

## Verification
The assertions check on every cycle that execute messages are never back-pressured and always produce a training strobe. They also check that a mispredict loads its target and flips the execute epoch, that a mispredict shuts out both the decode path and the tag, that a stale decode message leaves the PC and epochs untouched, and that an accepted tag moves the PC to its prediction. Only the bench scenarios show the order of whole sequences. For example, a decode message held back by an execute mispredict turns stale in the following cycle and is then dropped. The scenarios also show the epoch values that the tags carry after several redirects in a row, and that sequential fetch follows the predictor's answers.

// File: rtl/fra_pkg.sv
package fra_pkg;

  typedef enum logic [1:0] {
    ACT_FETCH    = 2'd0,
    ACT_EXE_REDIR = 2'd1,
    ACT_DEC_APPLY = 2'd2,
    ACT_DEC_DROP  = 2'd3
  } fra_action_e;

  // Pick this cycle's action from the pending messages and the epoch copy.
  function automatic fra_action_e fra_pick(input logic exe_v, input logic exe_mis,
                                           input logic dec_v, input logic dec_ep,
                                           input logic fe_ep);
    if (exe_v && exe_mis)  return ACT_EXE_REDIR;
    if (dec_v && (dec_ep == fe_ep)) return ACT_DEC_APPLY;
    if (dec_v)             return ACT_DEC_DROP;
    return ACT_FETCH;
  endfunction

  // Toggle an epoch bit when its source redirects.
  function automatic logic fra_epoch_next(input logic cur, input logic flip);
    return cur ^ flip;
  endfunction

endpackage

// File: rtl/fra_decide.sv
module fra_decide
  import fra_pkg::*;
(
  input  logic        exe_valid,
  input  logic        exe_mispred,
  input  logic        dec_valid,
  input  logic        dec_eep,
  input  logic        fe_ep,
  output fra_action_e action,
  output logic        dec_take,
  output logic        fetch_offer
);
  always_comb begin
    action      = fra_pick(exe_valid, exe_mispred, dec_valid, dec_eep, fe_ep);
    dec_take    = (action == ACT_DEC_APPLY) || (action == ACT_DEC_DROP);
    fetch_offer = (action == ACT_FETCH);
  end
endmodule

// File: rtl/fra_state.sv
module fra_state
  import fra_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]   RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fra_action_e       action,
  input  logic              fetch_fire,
  input  logic [ADDR_W-1:0] exe_target,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic [ADDR_W-1:0] pred_pc,
  output logic [ADDR_W-1:0] pc_q,
  output logic              fe_ep_q,
  output logic              fd_ep_q
);
  logic [ADDR_W-1:0] pc_d;
  logic              flip_e;
  logic              flip_d;

  always_comb begin
    pc_d   = pc_q;
    flip_e = 1'b0;
    flip_d = 1'b0;
    unique case (action)
      ACT_EXE_REDIR: begin pc_d = exe_target; flip_e = 1'b1; end
      ACT_DEC_APPLY: begin pc_d = dec_target; flip_d = 1'b1; end
      ACT_DEC_DROP:  pc_d = pc_q;
      ACT_FETCH:     if (fetch_fire) pc_d = pred_pc;
      default:       pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      fe_ep_q <= 1'b0;
      fd_ep_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      fe_ep_q <= fra_epoch_next(fe_ep_q, flip_e);
      fd_ep_q <= fra_epoch_next(fd_ep_q, flip_d);
    end
  end
endmodule

// File: rtl/fra_train.sv
module fra_train #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              exe_valid,
  input  logic [ADDR_W-1:0] exe_pc,
  input  logic [ADDR_W-1:0] exe_target,
  input  logic              exe_taken,
  input  logic              exe_mispred,
  output logic              train_valid,
  output logic [ADDR_W-1:0] train_pc,
  output logic [ADDR_W-1:0] train_target,
  output logic              train_taken,
  output logic              train_mispred
);
  always_comb begin
    train_valid   = exe_valid;
    train_pc      = exe_valid ? exe_pc     : '0;
    train_target  = exe_valid ? exe_target : '0;
    train_taken   = exe_valid & exe_taken;
    train_mispred = exe_valid & exe_mispred;
  end
endmodule

// File: rtl/fetch_redirect_arbiter.sv
module fetch_redirect_arbiter
  import fra_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exe_valid,
  input  logic [ADDR_W-1:0] exe_pc,
  input  logic [ADDR_W-1:0] exe_target,
  input  logic              exe_taken,
  input  logic              exe_mispred,
  output logic              exe_ready,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic              dec_eep,
  output logic              dec_ready,
  output logic [ADDR_W-1:0] pred_query_pc,
  input  logic [ADDR_W-1:0] pred_next_pc,
  output logic              train_valid,
  output logic [ADDR_W-1:0] train_pc,
  output logic [ADDR_W-1:0] train_target,
  output logic              train_taken,
  output logic              train_mispred,
  output logic              tag_valid,
  input  logic              tag_ready,
  output logic [ADDR_W-1:0] tag_pc,
  output logic [ADDR_W-1:0] tag_ppc,
  output logic              tag_eep,
  output logic              tag_dep
);
  fra_action_e       action;
  logic              dec_take;
  logic              fetch_offer;
  logic              fetch_fire;
  logic [ADDR_W-1:0] pc_q;
  logic              fe_ep_q;
  logic              fd_ep_q;

  fra_decide u_decide (
    .exe_valid  (exe_valid),
    .exe_mispred(exe_mispred),
    .dec_valid  (dec_valid),
    .dec_eep    (dec_eep),
    .fe_ep      (fe_ep_q),
    .action     (action),
    .dec_take   (dec_take),
    .fetch_offer(fetch_offer)
  );

  assign fetch_fire = fetch_offer & tag_ready;

  fra_state #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .action    (action),
    .fetch_fire(fetch_fire),
    .exe_target(exe_target),
    .dec_target(dec_target),
    .pred_pc   (pred_next_pc),
    .pc_q      (pc_q),
    .fe_ep_q   (fe_ep_q),
    .fd_ep_q   (fd_ep_q)
  );

  fra_train #(.ADDR_W(ADDR_W)) u_train (
    .exe_valid    (exe_valid),
    .exe_pc       (exe_pc),
    .exe_target   (exe_target),
    .exe_taken    (exe_taken),
    .exe_mispred  (exe_mispred),
    .train_valid  (train_valid),
    .train_pc     (train_pc),
    .train_target (train_target),
    .train_taken  (train_taken),
    .train_mispred(train_mispred)
  );

  assign exe_ready     = exe_valid;
  assign dec_ready     = dec_take;
  assign pred_query_pc = pc_q;
  assign tag_valid     = fetch_offer;
  assign tag_pc        = pc_q;
  assign tag_ppc       = pred_next_pc;
  assign tag_eep       = fe_ep_q;
  assign tag_dep       = fd_ep_q;
endmodule

// File: rtl/fra_checker.sv
module fra_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exe_valid,
  input logic              exe_mispred,
  input logic [ADDR_W-1:0] exe_target,
  input logic              exe_ready,
  input logic              train_valid,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic              dec_eep,
  input logic              tag_valid,
  input logic              tag_ready,
  input logic [ADDR_W-1:0] tag_ppc,
  input logic [ADDR_W-1:0] pc_q,
  input logic              fe_ep_q,
  input logic              fd_ep_q
);
  assert_exe_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |-> (exe_ready && train_valid));

  assert_exe_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && exe_mispred) |=> (pc_q == $past(exe_target)) && (fe_ep_q != $past(fe_ep_q)));

  assert_exe_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && exe_mispred) |-> (!dec_ready && !tag_valid));

  assert_stale_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && (dec_eep != fe_ep_q)) |=> ($stable(pc_q) && $stable(fe_ep_q) && $stable(fd_ep_q)));

  assert_dec_no_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !tag_valid);

  assert_fetch_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_ready) |=> (pc_q == $past(tag_ppc)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready) |=> $stable(pc_q));
endmodule

bind fetch_redirect_arbiter fra_checker #(.ADDR_W(ADDR_W)) u_fra_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .exe_valid  (exe_valid),
  .exe_mispred(exe_mispred),
  .exe_target (exe_target),
  .exe_ready  (exe_ready),
  .train_valid(train_valid),
  .dec_valid  (dec_valid),
  .dec_ready  (dec_ready),
  .dec_eep    (dec_eep),
  .tag_valid  (tag_valid),
  .tag_ready  (tag_ready),
  .tag_ppc    (tag_ppc),
  .pc_q       (pc_q),
  .fe_ep_q    (fe_ep_q),
  .fd_ep_q    (fd_ep_q)
);

// File: tb/tb_fetch_redirect_arbiter.sv
`timescale 1ns/1ps
module tb_fetch_redirect_arbiter;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exe_valid = 1'b0, exe_taken = 1'b0, exe_mispred = 1'b0;
  logic [AW-1:0] exe_pc = '0, exe_target = '0;
  logic          exe_ready;
  logic          dec_valid = 1'b0, dec_eep = 1'b0;
  logic [AW-1:0] dec_target = '0;
  logic          dec_ready;
  logic [AW-1:0] pred_query_pc, pred_next_pc;
  logic          train_valid, train_taken, train_mispred;
  logic [AW-1:0] train_pc, train_target;
  logic          tag_valid, tag_eep, tag_dep;
  logic          tag_ready = 1'b0;
  logic [AW-1:0] tag_pc, tag_ppc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Predictor model: sequential guess, four bytes ahead.
  assign pred_next_pc = pred_query_pc + 32'd4;

  fetch_redirect_arbiter #(.ADDR_W(AW), .RESET_PC(32'h0)) dut (
    .clk(clk), .rst_n(rst_n),
    .exe_valid(exe_valid), .exe_pc(exe_pc), .exe_target(exe_target),
    .exe_taken(exe_taken), .exe_mispred(exe_mispred), .exe_ready(exe_ready),
    .dec_valid(dec_valid), .dec_target(dec_target), .dec_eep(dec_eep), .dec_ready(dec_ready),
    .pred_query_pc(pred_query_pc), .pred_next_pc(pred_next_pc),
    .train_valid(train_valid), .train_pc(train_pc), .train_target(train_target),
    .train_taken(train_taken), .train_mispred(train_mispred),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_pc(tag_pc), .tag_ppc(tag_ppc),
    .tag_eep(tag_eep), .tag_dep(tag_dep)
  );

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    exe_valid = 0; exe_mispred = 0; exe_taken = 0; dec_valid = 0;
  endtask

  // Advance one cycle: cross posedge, land on negedge, settle.
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check_tag(input string req, input logic [AW-1:0] pc, input logic ee, input logic de);
    chk(req, "tag_valid", tag_valid, 1);
    chk(req, "tag_pc", tag_pc, pc);
    chk(req, "tag_ppc", tag_ppc, pc + 4);
    chk(req, "tag_eep", tag_eep, ee);
    chk(req, "tag_dep", tag_dep, de);
  endtask

  task automatic t_reset();
    check_tag("R8", 32'h0, 0, 0);
    chk("R1", "train_valid idle", train_valid, 0);
  endtask

  task automatic t_seq();
    tag_ready = 1;
    step(); check_tag("R6", 32'h4, 0, 0);
    step(); check_tag("R6", 32'h8, 0, 0);
    tag_ready = 0;
  endtask

  task automatic t_stall();
    step(); check_tag("R7", 32'h8, 0, 0);
    step(); check_tag("R7", 32'h8, 0, 0);
  endtask

  task automatic t_exe_mis();
    exe_valid = 1; exe_mispred = 1; exe_taken = 1; exe_pc = 32'h8; exe_target = 32'h100;
    #1;
    chk("R1", "exe_ready", exe_ready, 1);
    chk("R1", "train_valid", train_valid, 1);
    chk("R1", "train_pc", train_pc, 32'h8);
    chk("R1", "train_target", train_target, 32'h100);
    chk("R1", "train_taken", train_taken, 1);
    chk("R1", "train_mispred", train_mispred, 1);
    chk("R3", "tag_valid", tag_valid, 0);
    @(negedge clk); clear_in(); #1;
    check_tag("R2", 32'h100, 1, 0);
  endtask

  task automatic t_exe_ok();
    tag_ready = 1;
    exe_valid = 1; exe_mispred = 0; exe_taken = 0; exe_pc = 32'h40; exe_target = 32'h44;
    #1;
    chk("R1", "train_valid ok", train_valid, 1);
    chk("R1", "train_mispred ok", train_mispred, 0);
    chk("R6", "tag with exe ok", tag_valid, 1);
    @(negedge clk); clear_in(); tag_ready = 0; #1;
    check_tag("R6", 32'h104, 1, 0);
  endtask

  task automatic t_dec_match();
    dec_valid = 1; dec_eep = 1; dec_target = 32'h200;
    #1;
    chk("R4", "dec_ready", dec_ready, 1);
    chk("R4", "tag_valid", tag_valid, 0);
    @(negedge clk); clear_in(); #1;
    check_tag("R4", 32'h200, 1, 1);
  endtask

  task automatic t_dec_stale();
    dec_valid = 1; dec_eep = 0; dec_target = 32'h300;
    #1;
    chk("R5", "dec_ready", dec_ready, 1);
    chk("R5", "tag_valid", tag_valid, 0);
    @(negedge clk); clear_in(); #1;
    check_tag("R5", 32'h200, 1, 1);
  endtask

  task automatic t_both();
    exe_valid = 1; exe_mispred = 1; exe_pc = 32'h200; exe_target = 32'h400;
    dec_valid = 1; dec_eep = 1; dec_target = 32'h500;
    #1;
    chk("R3", "dec_ready", dec_ready, 0);
    chk("R3", "tag_valid", tag_valid, 0);
    @(negedge clk); exe_valid = 0; exe_mispred = 0; #1;
    chk("R3", "held dec now stale, accepted", dec_ready, 1);
    chk("R3", "no tag on drop", tag_valid, 0);
    @(negedge clk); clear_in(); #1;
    check_tag("R3", 32'h400, 0, 1);
  endtask

  task automatic t_exe_ok_dec();
    exe_valid = 1; exe_mispred = 0; exe_pc = 32'h10; exe_target = 32'h14;
    dec_valid = 1; dec_eep = 0; dec_target = 32'h600;
    #1;
    chk("R9", "train_valid", train_valid, 1);
    chk("R9", "dec_ready", dec_ready, 1);
    @(negedge clk); clear_in(); #1;
    check_tag("R9", 32'h600, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        t_reset();
        t_seq();
        t_stall();
        t_exe_mis();
        t_exe_ok();
        t_dec_match();
        t_dec_stale();
        t_both();
        t_exe_ok_dec();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule